// File: doc/BRIEF.md
# Serial-Programmed Five-Bit Configuration Register with Output Selector

This block is an I2C target that holds a five-bit configuration value and steers it onto two output groups. The low four bits of the value feed a four-bit selectable output port. That port can instead pass four external inputs straight through. The remaining bit drives a single separate output. A host programs the value with one address byte followed by one data byte. A read returns the value in the same layout, with the three top bits cleared.

Two control pins pick what the outputs show. The override pin is active low. The select pin chooses between the stored bits and the external inputs. When override is low and select rises, the separate output freezes at the level it had just before the rise. The nonvolatile store is modelled as an ordinary register loaded with a reset default. The select pin is registered once, so the output group follows it one clock later.

Top module: `i2c_cfg_mux`

## Requirements
- R1: The target answers only the 7-bit address DEV_ADDR (default 1110100), sent MSB first with the R/W bit after it. A 0 in that bit means write and a 1 means read. It pulls SDA low in the acknowledge slot of a matching address. A non-matching address gets no acknowledge, and the target stays silent until the next START.
- R2: After a matching write address, the target acknowledges one data byte. If `wp` is low and byte bits 7..5 are zero, byte bits 4..0 become the configuration.
- R3: While `wp` is high, a write is still acknowledged but leaves the configuration unchanged.
- R4: A write byte with any of bits 7..5 set is acknowledged and discarded.
- R5: A read transfers one byte MSB first: bits 7..5 are zero, bit 4 is the separate-output bit and bits 3..0 are the port bits. The target then releases SDA and waits for STOP.
- R6: With `ovr_n` low and the registered select low, `mux_out` and `solo_out` are all zero.
- R7: When the registered select is high, `mux_out` equals `ext_in`, whatever the override level.
- R8: With `ovr_n` low and the registered select high, `solo_out` holds the level it had in the cycle before select rose. Later writes do not change it.
- R9: With `ovr_n` high, `solo_out` equals configuration bit 4. `mux_out` equals configuration bits 3..0 while the registered select is low.
- R10: Reset loads the configuration with RST_VAL and clears the registered select and the held level.
- R11: A repeated START restarts address reception at any point. STOP returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Drives the data line low when high |
| ovr_n | input | 1 | Active-low override |
| sel | input | 1 | High selects external inputs for the port |
| wp | input | 1 | High blocks register writes |
| ext_in | input | 4 | External inputs for the port |
| mux_out | output | 4 | Selectable output port |
| solo_out | output | 1 | Separate output |

## Verification
The bench keeps the default address 1110100 and overrides RST_VAL to 5'b10110. With that reset value, the reset state is visible on both output groups and cannot be confused with an all-zero register. The bus runs at ten system clocks per quarter bit. This gives the synchronizer and edge detector room, so acknowledge and read bits can be sampled mid-high. The default address lets the bench probe a neighbour address that differs only in its last bit.

// File: rtl/i2c_cfg_mux.sv
module i2c_cfg_mux #(
  parameter logic [6:0] DEV_ADDR = 7'b1110100,
  parameter logic [4:0] RST_VAL  = 5'b00000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       ovr_n,
  input  logic       sel,
  input  logic       wp,
  input  logic [3:0] ext_in,
  output logic [3:0] mux_out,
  output logic       solo_out
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_WAIT} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic [7:0] sr;
  logic [3:0] cnt;
  logic       rw;
  logic [4:0] cfg;
  logic       sel_q, hold_bit;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start    = scl_s & scl_p & sda_p & ~sda_s;
  wire stop     = scl_s & scl_p & ~sda_p & sda_s;
  wire [7:0] rd_byte = {3'b000, cfg};

  assign mux_out  = sel_q ? ext_in : (ovr_n ? cfg[3:0] : 4'b0000);
  assign solo_out = ovr_n ? cfg[4] : (sel_q & hold_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy   <= 2'b11;
      sda_sy   <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      st       <= S_IDLE;
      sr       <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      sda_oe   <= 1'b0;
      cfg      <= RST_VAL;
      sel_q    <= 1'b0;
      hold_bit <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
      sel_q  <= sel;
      if (sel && !sel_q)
        hold_bit <= ovr_n ? cfg[4] : 1'b0;

      if (start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sr[7:1] == DEV_ADDR) begin
                rw     <= sr[0];
                sda_oe <= 1'b1;
                st     <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_AACK:
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sr     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                st     <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WR;
              end
            end
          S_WR:
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1;
              st     <= S_WACK;
              if (!wp && sr[7:5] == 3'b000)
                cfg <= sr[4:0];
            end
          S_WACK:
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= S_WAIT;
            end
          S_RD:
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_WAIT;
              end else begin
                sr     <= {sr[6:0], 1'b0};
                sda_oe <= ~sr[6];
                cnt    <= cnt + 4'd1;
              end
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_mux_chk.sv
module i2c_cfg_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovr_n,
  input logic       sel_q,
  input logic       wp,
  input logic [3:0] ext_in,
  input logic [3:0] mux_out,
  input logic       solo_out,
  input logic [4:0] cfg
);
  // R6
  ovr_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_n && !sel_q) |-> (mux_out == 4'b0000 && !solo_out));

  // R7
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> (mux_out == ext_in));

  // R8
  held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_n && $past(!ovr_n) && sel_q && $past(sel_q)) |-> $stable(solo_out));

  // R9
  solo_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_n |-> (solo_out == cfg[4]));

  // R9
  port_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_n && !sel_q) |-> (mux_out == cfg[3:0]));

  // R3
  wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp) |-> $stable(cfg));
endmodule

bind i2c_cfg_mux i2c_cfg_mux_chk u_chk (.*);

// File: tb/i2c_cfg_mux_test.sv
module i2c_cfg_mux_test;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'b1110100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ovr_n = 1'b1, sel = 1'b0, wp = 1'b0;
  logic [3:0] ext_in = 4'b0000;
  logic sda_oe, solo_out;
  logic [3:0] mux_out;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  i2c_cfg_mux #(.RST_VAL(5'b10110)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ovr_n(ovr_n), .sel(sel), .wp(wp), .ext_in(ext_in),
    .mux_out(mux_out), .solo_out(solo_out));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitq(); repeat (Q) @(negedge clk); endtask
  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq(); sda_m = 1'b1; waitq();
  endtask

  task automatic clock_bit(input logic b, output logic got);
    sda_m = b; waitq(); scl_m = 1'b1; waitq();
    got = sda_line; waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], g);
    clock_bit(1'b1, g);
    ack = ~g;
  endtask

  task automatic i2c_wr(input logic [6:0] a, input logic [7:0] d, output logic ka, output logic kd);
    i2c_start(); send_byte({a, 1'b0}, ka); send_byte(d, kd); i2c_stop();
  endtask

  task automatic i2c_rd(input logic [6:0] a, output logic ka, output logic [7:0] d);
    logic g;
    i2c_start(); send_byte({a, 1'b1}, ka);
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, g); d[i] = g; end
    clock_bit(1'b1, g);
    i2c_stop();
  endtask

  task automatic t_reset();
    settle();
    check("R10 port", {4'b0, mux_out}, 8'h06);
    check("R10 solo", {7'b0, solo_out}, 8'h01);
    check("R10 sda", {7'b0, sda_oe}, 8'h00);
  endtask

  task automatic t_write();
    logic ka, kd;
    i2c_wr(ADDR, 8'h0B, ka, kd);
    check("R1 addr ack", {7'b0, ka}, 8'h01);
    check("R2 data ack", {7'b0, kd}, 8'h01);
    check("R2 port", {4'b0, mux_out}, 8'h0B);
    check("R2 solo", {7'b0, solo_out}, 8'h00);
  endtask

  task automatic t_bad_addr();
    logic ka, kd;
    i2c_wr(7'b1110101, 8'h15, ka, kd);
    check("R1 no ack", {7'b0, ka}, 8'h00);
    check("R1 data ignored", {7'b0, kd}, 8'h00);
    check("R1 port kept", {4'b0, mux_out}, 8'h0B);
  endtask

  task automatic t_wp();
    logic ka, kd;
    wp = 1'b1;
    i2c_wr(ADDR, 8'h1F, ka, kd);
    wp = 1'b0;
    check("R3 ack", {7'b0, kd}, 8'h01);
    check("R3 port kept", {4'b0, mux_out}, 8'h0B);
    check("R3 solo kept", {7'b0, solo_out}, 8'h00);
  endtask

  task automatic t_upper();
    logic ka, kd;
    i2c_wr(ADDR, 8'h35, ka, kd);
    check("R4 ack", {7'b0, kd}, 8'h01);
    check("R4 port kept", {4'b0, mux_out}, 8'h0B);
    i2c_wr(ADDR, 8'h95, ka, kd);
    check("R4 bit7 port kept", {4'b0, mux_out}, 8'h0B);
  endtask

  task automatic t_read();
    logic ka, kd;
    logic [7:0] d;
    i2c_wr(ADDR, 8'h1A, ka, kd);
    i2c_rd(ADDR, ka, d);
    check("R5 addr ack", {7'b0, ka}, 8'h01);
    check("R5 data", d, 8'h1A);
    check("R5 released", {7'b0, sda_oe}, 8'h00);
  endtask

  task automatic t_restart();
    logic ka, kd, g;
    i2c_start();
    for (int i = 0; i < 3; i++) clock_bit(1'b1, g);
    i2c_start();
    send_byte({ADDR, 1'b0}, ka);
    send_byte(8'h05, kd);
    i2c_stop();
    check("R11 ack after restart", {7'b0, ka}, 8'h01);
    check("R11 port", {4'b0, mux_out}, 8'h05);
  endtask

  task automatic t_modes();
    ext_in = 4'b1001;
    ovr_n = 1'b0; sel = 1'b0; settle();
    check("R6 port zero", {4'b0, mux_out}, 8'h00);
    check("R6 solo zero", {7'b0, solo_out}, 8'h00);
    ovr_n = 1'b1; sel = 1'b1; settle();
    check("R7 port ext ovr high", {4'b0, mux_out}, 8'h09);
    check("R9 solo cfg", {7'b0, solo_out}, 8'h00);
    sel = 1'b0; settle();
    check("R9 port cfg", {4'b0, mux_out}, 8'h05);
  endtask

  task automatic t_latch();
    logic ka, kd;
    i2c_wr(ADDR, 8'h13, ka, kd);
    ovr_n = 1'b0; sel = 1'b0; settle();
    sel = 1'b1; settle();
    check("R8 latched low", {7'b0, solo_out}, 8'h00);
    check("R7 port ext", {4'b0, mux_out}, 8'h09);
    sel = 1'b0; ovr_n = 1'b1; settle();
    check("R9 solo high", {7'b0, solo_out}, 8'h01);
    sel = 1'b1; settle();
    ovr_n = 1'b0; settle();
    check("R8 latched high", {7'b0, solo_out}, 8'h01);
    i2c_wr(ADDR, 8'h02, ka, kd);
    check("R8 held across write", {7'b0, solo_out}, 8'h01);
    ovr_n = 1'b1; settle();
    check("R9 solo follows cfg", {7'b0, solo_out}, 8'h00);
    sel = 1'b0; settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_bad_addr();
    t_wp();
    t_upper();
    t_read();
    t_restart();
    t_modes();
    t_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule